// File: doc/BRIEF.md
# Serial Snoop Chain Controller

This controller serves one coherence snoop at a time on a bus shared by a ring of caches. It does not check every cache's tag array at once. It checks the tag arrays one after another, in ring order from the node that raised the request. It stops as soon as one node reports a tag match. The aim is to save the energy of tag lookups that would miss. The cost is a latency that grows with the distance to the node that holds the line.

A request carries the requesting node's id and the line address. It is taken only while `req_ready` is high. The controller holds the address on `probe_addr` and raises exactly one bit of `probe_en` in each cycle. The probed node answers on its bit of `tag_hit` in the same cycle. One cycle after the match, the controller raises `done`, reports the node on `src_id`, and enables a data-array read for that node only. The data array is therefore read only after a tag hit. If no node holds the line, every other node is checked, and `done` then reports that no node has it.

Top module: `snoop_chain_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, `req_ready` is 1 and `probe_en`, `rd_en` and `done` are 0. Reset aborts a snoop in progress.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. Requests raised while a snoop runs do not change the node order, the address or the result of that snoop.
- R3: The cycle after acceptance probes node (requester+1) mod NUM_NODES. `probe_en` bit i selects node i, and at most one bit is set in any cycle.
- R4: Each later probe moves to the next node in the ring, (requester+s) mod NUM_NODES at step s. The requester itself is never probed.
- R5: When the probed node reports a tag match, probing stops. In the next cycle `done` is 1, `found` is 1 and `src_id` holds that node's id. This gives completion s cycles after the first probe for a hit at step s.
- R6: If none of the NUM_NODES-1 probes matches, `done` rises in the cycle after the last probe with `found` 0 and `src_id` 0.
- R7: `rd_en` is one-hot on the matching node only in the `done` cycle of a hit. It is 0 in every other cycle, including a miss.
- R8: `tag_hit` bits of nodes that are not being probed are ignored, including the requester's bit and any bits seen while idle.
- R9: `probe_addr` equals the accepted address in every probe cycle of a snoop.
- R10: `req_ready` is 0 from acceptance through the `done` cycle and returns to 1 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Snoop request present |
| req_id | input | $clog2(NUM_NODES) | Id of the requesting node |
| req_addr | input | ADDR_W | Line address to look up |
| req_ready | output | 1 | Controller idle, request may be taken |
| probe_en | output | NUM_NODES | One-hot tag-probe enable, bit i for node i |
| probe_addr | output | ADDR_W | Address presented to the probed tag array |
| tag_hit | input | NUM_NODES | Per-node tag match result for the current probe |
| rd_en | output | NUM_NODES | One-hot data-array read enable for the matching node |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Line found in a cache (valid with done) |
| src_id | output | $clog2(NUM_NODES) | Matching node id, 0 when none (valid with done) |

## Verification
The bound checker watches the cycle-level rules on every cycle. These are the one-hot probe enable, silence while idle, the stop and read enable right after a match, a stable address during a probe run, the "none" encoding of a miss, and the return to ready after completion. Only the bench scenarios can show that the probe order follows the ring from the requester and skips it, and that a full miss takes exactly NUM_NODES-1 probes. They also show that requests raised during a busy snoop and stray hit bits leave the result unchanged, and that reset in the middle of a snoop recovers cleanly.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_RESP  = 2'd2
  } snoop_state_e;
endpackage

// File: rtl/snoop_ring_step.sv
// Node reached by walking STEP positions round the ring from BASE.
module snoop_ring_step #(
  parameter int NUM_NODES = 4,
  parameter int ID_W      = $clog2(NUM_NODES)
) (
  input  logic [ID_W-1:0] base,
  input  logic [ID_W-1:0] step,
  output logic [ID_W-1:0] node
);
  localparam bit POW2 = (NUM_NODES == (1 << ID_W));
  localparam logic [ID_W:0] RING = (ID_W+1)'(NUM_NODES);

  logic [ID_W:0] sum;
  assign sum = {1'b0, base} + {1'b0, step};

  generate
    if (POW2) begin : g_wrap_free
      assign node = sum[ID_W-1:0];
    end else begin : g_wrap_sub
      logic [ID_W:0] wrapped;
      assign wrapped = (sum >= RING) ? (sum - RING) : sum;
      assign node    = wrapped[ID_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/snoop_onehot.sv
// Index to gated one-hot vector.
module snoop_onehot #(
  parameter int NUM_NODES = 4,
  parameter int ID_W      = $clog2(NUM_NODES)
) (
  input  logic [ID_W-1:0]      idx,
  input  logic                 en,
  output logic [NUM_NODES-1:0] vec
);
  generate
    for (genvar i = 0; i < NUM_NODES; i++) begin : g_bit
      assign vec[i] = en && (idx == ID_W'(i));
    end
  endgenerate
endmodule

// File: rtl/snoop_seq.sv
// Sequencer: capture, step through the ring, hold the outcome.
module snoop_seq
  import snoop_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = $clog2(NUM_NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   cur_node,
  input  logic              probe_hit,
  output snoop_state_e      state_q,
  output logic [ID_W-1:0]   base_q,
  output logic [ID_W-1:0]   step_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ID_W-1:0]   node_q,
  output logic              found_q
);
  localparam logic [ID_W-1:0] LAST_STEP  = ID_W'(NUM_NODES - 1);
  localparam logic [ID_W-1:0] FIRST_STEP = ID_W'(1);

  snoop_state_e      state_d;
  logic [ID_W-1:0]   step_d;
  logic [ID_W-1:0]   node_d;
  logic              found_d;
  logic              cap_en;
  logic              step_en;
  logic              res_en;
  logic              last;

  assign last = (step_q == LAST_STEP);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    node_d  = node_q;
    found_d = found_q;
    cap_en  = 1'b0;
    step_en = 1'b0;
    res_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_PROBE;
          cap_en  = 1'b1;
          step_en = 1'b1;
          step_d  = FIRST_STEP;
        end
      end
      ST_PROBE: begin
        if (probe_hit || last) begin
          state_d = ST_RESP;
          res_en  = 1'b1;
          node_d  = cur_node;
          found_d = probe_hit;
        end else begin
          step_en = 1'b1;
          step_d  = step_q + FIRST_STEP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      addr_q  <= '0;
      step_q  <= '0;
      node_q  <= '0;
      found_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        base_q <= req_id;
        addr_q <= req_addr;
      end
      if (step_en) step_q <= step_d;
      if (res_en) begin
        node_q  <= node_d;
        found_q <= found_d;
      end
    end
  end
endmodule

// File: rtl/snoop_chain_ctrl.sv
module snoop_chain_ctrl
  import snoop_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = $clog2(NUM_NODES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ID_W-1:0]      req_id,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 req_ready,
  output logic [NUM_NODES-1:0] probe_en,
  output logic [ADDR_W-1:0]    probe_addr,
  input  logic [NUM_NODES-1:0] tag_hit,
  output logic [NUM_NODES-1:0] rd_en,
  output logic                 done,
  output logic                 found,
  output logic [ID_W-1:0]      src_id
);
  snoop_state_e      state_q;
  logic [ID_W-1:0]   base_q;
  logic [ID_W-1:0]   step_q;
  logic [ID_W-1:0]   node_q;
  logic [ID_W-1:0]   cur_node;
  logic              found_q;
  logic              probe_hit;
  logic              in_probe;
  logic              in_resp;

  assign in_probe = (state_q == ST_PROBE);
  assign in_resp  = (state_q == ST_RESP);

  snoop_seq #(.NUM_NODES(NUM_NODES), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .cur_node(cur_node), .probe_hit(probe_hit),
    .state_q(state_q), .base_q(base_q), .step_q(step_q),
    .addr_q(probe_addr), .node_q(node_q), .found_q(found_q)
  );

  snoop_ring_step #(.NUM_NODES(NUM_NODES), .ID_W(ID_W)) u_ring (
    .base(base_q), .step(step_q), .node(cur_node)
  );

  snoop_onehot #(.NUM_NODES(NUM_NODES), .ID_W(ID_W)) u_probe_dec (
    .idx(cur_node), .en(in_probe), .vec(probe_en)
  );

  snoop_onehot #(.NUM_NODES(NUM_NODES), .ID_W(ID_W)) u_read_dec (
    .idx(node_q), .en(in_resp && found_q), .vec(rd_en)
  );

  assign probe_hit = |(probe_en & tag_hit);
  assign req_ready = (state_q == ST_IDLE);
  assign done      = in_resp;
  assign found     = in_resp && found_q;
  assign src_id    = (in_resp && found_q) ? node_q : '0;
endmodule

// File: rtl/snoop_chain_ctrl_chk.sv
module snoop_chain_ctrl_chk #(
  parameter int NUM_NODES = 4,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = $clog2(NUM_NODES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic [NUM_NODES-1:0] probe_en,
  input logic [ADDR_W-1:0]    probe_addr,
  input logic [NUM_NODES-1:0] tag_hit,
  input logic [NUM_NODES-1:0] rd_en,
  input logic                 done,
  input logic                 found,
  input logic [ID_W-1:0]      src_id
);
  p_probe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_en));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (probe_en == '0 && rd_en == '0 && !done));

  p_stop_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(probe_en & tag_hit)) |=> (done && found && probe_en == '0));

  p_read_follows_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(probe_en & tag_hit)) |=> (rd_en == $past(probe_en)));

  p_read_only_on_found_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_en) |-> (done && found && $onehot(rd_en)));

  p_miss_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (src_id == '0 && rd_en == '0));

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|probe_en) && $past(|probe_en)) |-> $stable(probe_addr));

  p_ready_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));
endmodule

bind snoop_chain_ctrl snoop_chain_ctrl_chk #(
  .NUM_NODES(NUM_NODES), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .probe_en(probe_en),
  .probe_addr(probe_addr), .tag_hit(tag_hit), .rd_en(rd_en), .done(done),
  .found(found), .src_id(src_id)
);

// File: tb/snoop_chain_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_chain_ctrl_tb;
  localparam int K  = 4;
  localparam int AW = 16;
  localparam int IW = 2;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [IW-1:0] req_id;
  logic [AW-1:0] req_addr;
  logic          req_ready;
  logic [K-1:0]  probe_en;
  logic [AW-1:0] probe_addr;
  logic [K-1:0]  tag_hit;
  logic [K-1:0]  rd_en;
  logic          done;
  logic          found;
  logic [IW-1:0] src_id;

  snoop_chain_ctrl #(.NUM_NODES(K), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_addr(req_addr), .req_ready(req_ready), .probe_en(probe_en),
    .probe_addr(probe_addr), .tag_hit(tag_hit), .rd_en(rd_en),
    .done(done), .found(found), .src_id(src_id)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [IW-1:0] id;
    logic [AW-1:0] addr;
    logic [K-1:0]  mask;
    logic          busy;
  } vec_t;

  // mask bit i = node i answers a tag match whenever probed
  localparam vec_t VECS [8] = '{
    '{2'd0, 16'h1A00, 4'b0010, 1'b0},  // hit at step 1
    '{2'd0, 16'h2B40, 4'b1000, 1'b0},  // hit at last step
    '{2'd2, 16'h3C80, 4'b0000, 1'b0},  // full miss
    '{2'd3, 16'h4DC0, 4'b0110, 1'b0},  // wrap: order 0,1,2
    '{2'd1, 16'h5E00, 4'b0011, 1'b0},  // requester bit set, hit node 0
    '{2'd2, 16'h6F40, 4'b0100, 1'b0},  // only requester bit: miss
    '{2'd1, 16'h7080, 4'b1111, 1'b1},  // busy requests during snoop
    '{2'd3, 16'h81C0, 4'b0000, 1'b1}   // busy miss
  };

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_snoop(input logic [IW-1:0] id, input logic [AW-1:0] addr,
                           input logic [K-1:0] mask, input logic busy);
    int hit_node;
    hit_node = -1;
    @(negedge clk);
    check("R2 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_id    = id;
    req_addr  = addr;
    tag_hit   = mask;
    @(negedge clk);
    if (busy) begin
      req_id   = id + 2'd1;
      req_addr = ~addr;
    end else begin
      req_valid = 1'b0;
    end
    for (int s = 1; s < K; s++) begin
      int node;
      node = (int'(id) + s) % K;
      if (s > 1) @(negedge clk);
      if (s == 1) check("R3 first probe", 32'(probe_en), 32'(1 << node));
      else        check("R4 ring probe",  32'(probe_en), 32'(1 << node));
      check("R9 probe address", 32'(probe_addr), 32'(addr));
      check("R10 busy not ready", 32'(req_ready), 32'd0);
      if (mask[node]) begin
        hit_node = node;
        break;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 R6 done pulse", 32'(done), 32'd1);
    check("R5 no probe after end", 32'(probe_en), 32'd0);
    if (hit_node >= 0) begin
      check("R5 found", 32'(found), 32'd1);
      check("R5 source id", 32'(src_id), 32'(hit_node));
      check("R7 read enable", 32'(rd_en), 32'(1 << hit_node));
    end else begin
      check("R6 not found", 32'(found), 32'd0);
      check("R6 none id", 32'(src_id), 32'd0);
      check("R7 no read on miss", 32'(rd_en), 32'd0);
    end
    @(negedge clk);
    check("R10 ready after done", 32'(req_ready), 32'd1);
    check("R10 done single cycle", 32'(done), 32'd0);
    check("R7 read single cycle", 32'(rd_en), 32'd0);
    tag_hit = '0;
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_id    = '0;
    req_addr  = '0;
    tag_hit   = '0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", 32'(req_ready), 32'd1);
    check("R1 reset probe", 32'(probe_en), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset read", 32'(rd_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release ready", 32'(req_ready), 32'd1);

    for (int v = 0; v < 8; v++)
      run_snoop(VECS[v].id, VECS[v].addr, VECS[v].mask, VECS[v].busy);

    // R8: hit bits while idle and no request
    tag_hit = 4'b1111;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R8 idle hits ignored", 32'({done, rd_en, probe_en}), 32'd0);
      check("R8 idle stays ready", 32'(req_ready), 32'd1);
    end
    tag_hit = '0;

    // R1: reset in the middle of a snoop
    @(negedge clk);
    req_valid = 1'b1; req_id = 2'd0; req_addr = 16'h9999;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 probe before abort", 32'(probe_en), 32'd2);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 abort probe", 32'(probe_en), 32'd0);
    check("R1 abort ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no done after abort", 32'(done), 32'd0);
    run_snoop(2'd2, 16'hA5A5, 4'b0001, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule